// File: doc/BRIEF.md
# Multi-Mode Test Observation Register

This block is an N-bit register whose single bank of flip-flops can take on four jobs, picked by a two-bit mode code. It can act as a plain parallel-load register in mission mode. It can act as a serial scan segment for shifting state in and out. It can run on its own as a linear-feedback pattern source for a downstream circuit under test. It can also fold a stream of parallel responses into a signature held in the same bits.

A test controller, which is outside this block, drives the two mode pins. In pattern mode the register runs freely from its reset seed. In signature mode the register compacts the outputs of the logic it observes, and the final value is read either in parallel or by switching to scan mode and shifting it out. The feedback taps and the reset seed are parameters, and the defaults give an 8-bit maximal-length sequence.

Top module: `test_obs_reg`

## Requirements
- R1: While `rst_n` is low, the register holds the seed parameter (default 8'h01). An asserted reset restores the seed at any time, even mid-run.
- R2: Mode code {mode_b1,mode_b2} = 2'b00 (scan) shifts the register one place toward the MSB on each clock, and `scan_in` enters bit 0.
- R3: Mode code 2'b01 (pattern) shifts toward the MSB and loads bit 0 with the XOR of the register bits selected by the tap mask (default 8'hB8, bits 7,5,4,3). `par_in` has no effect in this mode.
- R4: Mode code 2'b10 (normal) loads `par_in` into the register on each clock.
- R5: Mode code 2'b11 (signature) forms the pattern-mode next value and then XORs `par_in` into it bit by bit.
- R6: In pattern mode, starting from the seed 8'h01, the register never reaches zero and first returns to the seed after exactly 255 clocks.
- R7: A new mode code takes effect at the next rising clock edge and starts from the register contents that the previous mode left behind.
- R8: `scan_out` always equals the register MSB, in every mode. `par_out` always shows the whole register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, loads the seed |
| mode_b1 | input | 1 | Upper bit of the mode code |
| mode_b2 | input | 1 | Lower bit of the mode code |
| par_in | input | WIDTH | Parallel data or response input |
| scan_in | input | 1 | Serial input into bit 0 |
| par_out | output | WIDTH | Register contents |
| scan_out | output | 1 | Register MSB |

## Verification
The hardest condition to reach from the ports is the full pattern cycle. The bench has to run 255 consecutive pattern-mode clocks from a known seed, keep track of every state seen, and confirm that zero never appears and that the seed comes back only on the last clock. The stimulus gets there by pulsing reset to reload the seed and then holding the pattern code while `par_in` changes on every clock. That same run also shows that `par_in` is ignored. Mode handovers are reached by loading a known value in normal mode and switching codes on the next edge, so that the following mode must continue from that exact value.

// File: rtl/obs_pkg.sv
`timescale 1ns/1ps
package obs_pkg;
  typedef enum logic [1:0] {
    OBS_SHIFT = 2'b00,
    OBS_PRPG  = 2'b01,
    OBS_PLOAD = 2'b10,
    OBS_MISR  = 2'b11
  } obs_mode_e;
endpackage

// File: rtl/obs_feedback.sv
`timescale 1ns/1ps
module obs_feedback #(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS = 8'hB8
) (
  input  logic [WIDTH-1:0] state,
  output logic             fb
);
  logic [WIDTH:0] chain;

  assign chain[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_tap
      if (TAPS[gi]) begin : g_on
        assign chain[gi+1] = chain[gi] ^ state[gi];
      end else begin : g_off
        assign chain[gi+1] = chain[gi];
      end
    end
  endgenerate

  assign fb = chain[WIDTH];
endmodule

// File: rtl/obs_next.sv
`timescale 1ns/1ps
module obs_next
  import obs_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  obs_mode_e        mode,
  input  logic [WIDTH-1:0] state,
  input  logic             fb,
  input  logic [WIDTH-1:0] par_in,
  input  logic             scan_in,
  output logic [WIDTH-1:0] nxt
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] shifted_fb;

  assign shifted_fb = {state[MSB-1:0], fb};

  always_comb begin
    case (mode)
      OBS_SHIFT: nxt = {state[MSB-1:0], scan_in};
      OBS_PRPG:  nxt = shifted_fb;
      OBS_PLOAD: nxt = par_in;
      OBS_MISR:  nxt = shifted_fb ^ par_in;
      default:   nxt = state;
    endcase
  end
endmodule

// File: rtl/test_obs_reg.sv
`timescale 1ns/1ps
module test_obs_reg
  import obs_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS = 8'hB8,
  parameter logic [WIDTH-1:0] SEED = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_b1,
  input  logic             mode_b2,
  input  logic [WIDTH-1:0] par_in,
  input  logic             scan_in,
  output logic [WIDTH-1:0] par_out,
  output logic             scan_out
);
  localparam int unsigned MSB = WIDTH - 1;

  obs_mode_e        mode;
  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_nxt;
  logic             fb;

  assign mode = obs_mode_e'({mode_b1, mode_b2});

  obs_feedback #(.WIDTH(WIDTH), .TAPS(TAPS)) u_fb (
    .state (q_r),
    .fb    (fb)
  );

  obs_next #(.WIDTH(WIDTH)) u_nxt (
    .mode    (mode),
    .state   (q_r),
    .fb      (fb),
    .par_in  (par_in),
    .scan_in (scan_in),
    .nxt     (q_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= SEED;
    else        q_r <= q_nxt;
  end

  assign par_out  = q_r;
  assign scan_out = q_r[MSB];

  // R2: scan shifts up with scan_in at bit 0
  a_r2_scan_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OBS_SHIFT) |=>
      (par_out[MSB:1] == $past(par_out[MSB-1:0])) && (par_out[0] == $past(scan_in)));

  // R3: pattern mode upper bits are a pure shift, independent of par_in
  a_r3_prpg_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OBS_PRPG) |=> (par_out[MSB:1] == $past(par_out[MSB-1:0])));

  // R4: normal mode captures the parallel input
  a_r4_pload: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OBS_PLOAD) |=> (par_out == $past(par_in)));

  // R5: signature upper bits are shift XOR input
  a_r5_misr_fold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OBS_MISR) |=>
      ((par_out[MSB:1] ^ $past(par_in[MSB:1])) == $past(par_out[MSB-1:0])));

  // R6: pattern mode never falls into the all-zero state
  a_r6_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == OBS_PRPG) && (par_out != '0)) |=> (par_out != '0));
endmodule

// File: tb/test_obs_reg_bench.sv
`timescale 1ns/1ps
module test_obs_reg_bench;
  localparam int W = 8;
  localparam logic [W-1:0] SEED_V = 8'h01;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         mode_b1, mode_b2;
  logic [W-1:0] par_in;
  logic         scan_in;
  logic [W-1:0] par_out;
  logic         scan_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [W-1:0] expq;

  always #2.5 clk = ~clk;

  test_obs_reg u_test_obs_reg (
    .clk(clk), .rst_n(rst_n), .mode_b1(mode_b1), .mode_b2(mode_b2),
    .par_in(par_in), .scan_in(scan_in), .par_out(par_out), .scan_out(scan_out)
  );

  // Behavioural reference: integer-level parity over taps 7,5,4,3
  function automatic logic [W-1:0] ref_next(input logic [1:0] m, input logic [W-1:0] q,
                                            input logic [W-1:0] d, input logic s);
    int ones = 0;
    int t [4] = '{7, 5, 4, 3};
    int v;
    foreach (t[k]) ones += q[t[k]];
    v = (int'(q) * 2) % 256;
    case (m)
      2'b00: v = v + int'(s);
      2'b01: v = v + (ones % 2);
      2'b10: v = int'(d);
      default: v = (v + (ones % 2)) ^ int'(d);
    endcase
    return v[W-1:0];
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic [W-1:0] d, input logic s, input string req);
    mode_b1 = m[1];
    mode_b2 = m[0];
    par_in  = d;
    scan_in = s;
    expq    = ref_next(m, expq, d, s);
    @(negedge clk);
    chk(req, par_out, expq);
    chk("R8 scan_out", {7'd0, scan_out}, {7'd0, expq[W-1]});
  endtask

  task automatic pulse_reset();
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset seed", par_out, SEED_V);
    rst_n = 1'b1;
    expq  = SEED_V;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] scan_pat;
    int first_back;
    bit zero_seen;
    rst_n = 1'b0; mode_b1 = 1'b1; mode_b2 = 1'b0; par_in = '0; scan_in = 1'b0;
    expq = SEED_V;
    repeat (3) @(negedge clk);
    chk("R1 reset seed", par_out, SEED_V);
    chk("R8 scan_out in reset", {7'd0, scan_out}, 8'd0);
    rst_n = 1'b1;

    // R4 normal mode loads
    step(2'b10, 8'hA5, 1'b1, "R4 load A5");
    step(2'b10, 8'h3C, 1'b0, "R4 load 3C");
    step(2'b10, 8'hFF, 1'b0, "R4 load FF");
    step(2'b10, 8'h96, 1'b1, "R4 load 96");

    // R7 handover into pattern mode, R3 with par_in churning
    for (int i = 0; i < 20; i++)
      step(2'b01, 8'(i * 37 + 11), i[0], "R3/R7 pattern from loaded value");

    // R2 scan in a pattern; R8 scan_out sequence checked inside step
    scan_pat = 8'b1011_0010;
    for (int i = 7; i >= 0; i--)
      step(2'b00, 8'h5A, scan_pat[i], "R2 scan shift");
    chk("R2 scanned pattern", par_out, scan_pat);

    // R5 signature compaction from a cleared register
    step(2'b10, 8'h00, 1'b0, "R4 clear");
    for (int i = 0; i < 16; i++)
      step(2'b11, 8'(i * 53 + 7), 1'b0, "R5 signature");
    // R7 switch to scan to unload the signature
    for (int i = 0; i < 8; i++)
      step(2'b00, 8'h00, 1'b0, "R7/R2 signature unload");

    // R1 mid-run reset, then R6 full period
    step(2'b10, 8'hC3, 1'b0, "R4 load C3");
    pulse_reset();
    first_back = 0;
    zero_seen  = 0;
    for (int i = 1; i <= 255; i++) begin
      step(2'b01, 8'(i * 91), 1'b1, "R3 pattern run");
      if (par_out == 8'h00) zero_seen = 1;
      if (par_out == SEED_V && first_back == 0) first_back = i;
    end
    chk("R6 period", 8'(first_back), 8'd255);
    chk("R6 no zero state", {7'd0, zero_seen}, 8'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule